// File: doc/BRIEF.md
# Two-Wire Serial Byte Controller

This block is a single-stepped master engine for a two-wire serial bus. Software moves it through a transaction one bus event at a time: a start, an address byte, data bytes in either direction, and a stop. Each event is launched by a write to the control register. When the event finishes, the controller raises an interrupt flag and leaves a standard eight-bit status code for software to read. Software picks the next event from that code.

The serial clock comes from the system clock. A period value and two divider fields set the rate. Each bit cell is cut into four equal quarters. SCL is released for the middle two quarters. SDA is changed only in the first quarter, while SCL is low. Both lines are open-drain: an output-enable high pulls the line low. Only master operation is supported.

Register map (3-bit address): 0 data, 1 control, 2 status (read only), 3 period, 4 divider control.

Top module: `twi_byte_master`

## Requirements
- R1: After reset the status reads 0xF8, control reads 0x00, the flag is low and both line enables are low (both lines released).
- R2: Control bits are: bit 6 enable, bit 5 start request, bit 4 stop request, bit 3 flag (read back), bit 2 acknowledge received bytes. A control write with bit 6 clear launches nothing and leaves the bus and the status unchanged.
- R3: A start request from the idle state makes SDA fall while SCL is high. It then sets the flag with status 0x08.
- R4: A start request while a transaction is open produces a repeated start with status 0x10.
- R5: The first byte after a start is the data register, sent MSB first. Bit 0 of that byte is the direction (1 = read). The step ends with status 0x18 (write, acked), 0x20 (write, not acked), 0x40 (read, acked) or 0x48 (read, not acked).
- R6: A write data byte is sent MSB first. It ends with status 0x28 if acked or 0x30 if not acked.
- R7: A read byte is shifted MSB first into the data register. With control bit 2 set, the master acks the byte and the status is 0x50. With bit 2 clear, the master sends a NACK and the status is 0x58.
- R8: A stop request during a transaction forms a stop condition, releases both lines and returns the status to 0xF8, without raising the flag. A stop request while idle does nothing.
- R9: The SCL period is 20·(P+1)·(M+1)·2^N system clocks. P is the period register. M is divider-control bits 6:3. N is bits 2:0.
- R10: The flag rises only at the end of a start or byte step. It is cleared by an accepted control write. Register writes that arrive while a step runs are ignored, including one in the step's final cycle.
- R11: SDA changes only while SCL is low, except for the falling edge of a start and the rising edge of a stop.
- R12: A control write carrying both start and stop requests performs only the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Step-complete flag |
| scl_oe | output | 1 | Pulls SCL low when high |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | Pulls SDA low when high |

## Verification
A control write can arrive in the cycle where a running byte step completes and sets the flag. The bench provokes this by repeating a stop-request write on every cycle of a data-byte step, up to and including the cycle in which the flag appears. The run is judged correct if the flag stays set afterwards, the status shows the acked-data code, SCL stays held low and the bus target sees no stop.

// File: rtl/twi_byte_master.sv
module twi_byte_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2, A_PER = 3'd3, A_DIV = 3'd4;
  localparam int CW = 24;
  localparam logic [7:0] ST_IDLE = 8'hF8;

  typedef enum logic [1:0] {OP_START, OP_BYTE, OP_STOP} op_t;

  logic [7:0] dat, st, thp;
  logic [6:0] dctl;
  logic       en, aak, flag, busy, active, need_addr, cur_addr, rd, ack_ok;
  op_t        op, op_nx, launch_op;
  logic [1:0] q, q_nx;
  logic [3:0] bitn, bit_nx;
  logic [CW-1:0] cnt, lim;
  logic       ctrl_wr, launch, tick, fin, step, enter, rx_cur, rx_nx;

  assign lim     = ((CW'(thp) + CW'(1)) * (CW'(dctl[6:3]) + CW'(1)) * CW'(5)) << dctl[2:0];
  assign tick    = (cnt == lim - CW'(1));
  assign ctrl_wr = reg_we && reg_addr == A_CTRL && !busy;
  assign launch  = ctrl_wr && reg_wdata[6] && (reg_wdata[5] || active);
  assign launch_op = reg_wdata[5] ? OP_START : (reg_wdata[4] ? OP_STOP : OP_BYTE);
  assign fin     = busy && tick && q == 2'd3 && (op != OP_BYTE || bitn == 4'd8);
  assign step    = busy && tick && !fin;
  assign enter   = launch || step;
  assign q_nx    = launch ? 2'd0 : q + 2'd1;
  assign bit_nx  = launch ? 4'd0 : (q == 2'd3 ? bitn + 4'd1 : bitn);
  assign op_nx   = launch ? launch_op : op;
  assign rx_cur  = !cur_addr && rd;
  assign rx_nx   = launch ? (!need_addr && rd) : rx_cur;
  assign irq     = flag;

  always_comb begin
    case (reg_addr)
      A_DATA:  reg_rdata = dat;
      A_CTRL:  reg_rdata = {1'b0, en, 2'b00, flag, aak, 2'b00};
      A_STAT:  reg_rdata = st;
      A_PER:   reg_rdata = thp;
      A_DIV:   reg_rdata = {1'b0, dctl};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else if (enter) begin
      case (op_nx)
        OP_START: case (q_nx)
          2'd0: sda_oe <= 1'b0;
          2'd1: scl_oe <= 1'b0;
          2'd2: sda_oe <= 1'b1;
          default: scl_oe <= 1'b1;
        endcase
        OP_STOP: case (q_nx)
          2'd0: sda_oe <= 1'b1;
          2'd1: scl_oe <= 1'b0;
          2'd2: sda_oe <= 1'b0;
          default: ;
        endcase
        default: case (q_nx)
          2'd0: sda_oe <= (bit_nx == 4'd8) ? (rx_nx && aak)
                                           : (!rx_nx && !dat[3'd7 - bit_nx[2:0]]);
          2'd1: scl_oe <= 1'b0;
          2'd3: scl_oe <= 1'b1;
          default: ;
        endcase
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat <= '0; st <= ST_IDLE; thp <= '0; dctl <= '0;
      en <= 1'b0; aak <= 1'b0; flag <= 1'b0; busy <= 1'b0; active <= 1'b0;
      need_addr <= 1'b0; cur_addr <= 1'b0; rd <= 1'b0; ack_ok <= 1'b0;
      op <= OP_START; q <= '0; bitn <= '0; cnt <= '0;
    end else begin
      if (reg_we && !busy) begin
        case (reg_addr)
          A_DATA: dat  <= reg_wdata;
          A_PER:  thp  <= reg_wdata;
          A_DIV:  dctl <= reg_wdata[6:0];
          default: ;
        endcase
      end
      if (ctrl_wr) begin
        en   <= reg_wdata[6];
        aak  <= reg_wdata[2];
        flag <= 1'b0;
      end
      if (launch) begin
        busy <= 1'b1; op <= launch_op; q <= '0; bitn <= '0; cnt <= '0;
        if (launch_op == OP_BYTE) begin
          cur_addr  <= need_addr;
          need_addr <= 1'b0;
          if (need_addr) rd <= dat[0];
        end
      end else if (busy) begin
        cnt <= tick ? '0 : cnt + CW'(1);
        if (step) begin
          q    <= q_nx;
          bitn <= bit_nx;
        end
      end
      if (step && op == OP_BYTE && q_nx == 2'd2) begin
        if (bitn != 4'd8) begin
          if (rx_cur) dat <= {dat[6:0], sda_i};
        end else begin
          ack_ok <= !sda_i;
        end
      end
      if (fin) begin
        busy <= 1'b0;
        case (op)
          OP_START: begin
            st <= active ? 8'h10 : 8'h08;
            active <= 1'b1; need_addr <= 1'b1; flag <= 1'b1;
          end
          OP_BYTE: begin
            flag <= 1'b1;
            if (cur_addr) st <= rd ? (ack_ok ? 8'h40 : 8'h48) : (ack_ok ? 8'h18 : 8'h20);
            else          st <= rd ? (aak ? 8'h50 : 8'h58)    : (ack_ok ? 8'h28 : 8'h30);
          end
          default: begin
            st <= ST_IDLE; active <= 1'b0; need_addr <= 1'b0;
          end
        endcase
      end
    end
  end

  p_flag_idle_r10: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !flag);
  p_flag_after_step_r10: assert property (@(posedge clk) disable iff (!rst_n) $rose(flag) |-> $past(busy));
  p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op == OP_BYTE && !$stable(sda_oe)) |-> scl_oe);
  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !busy) |-> (!scl_oe && !sda_oe));
  p_idle_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !busy) |-> st == ST_IDLE);
endmodule

// File: tb/twi_byte_master_tb.sv
module twi_byte_master_tb;
  localparam logic [2:0] A_DATA = 3'd0, A_CTRL = 3'd1, A_STAT = 3'd2, A_PER = 3'd3, A_DIV = 3'd4;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic s_low = 1'b0;
  logic scl_w, sda_w;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | s_low);

  twi_byte_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_oe(scl_oe), .sda_i(sda_w), .sda_oe(sda_oe));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  function automatic logic [7:0] rd_byte(input int k);
    return 8'hC3 ^ 8'(k * 37);
  endfunction

  // bus target model
  int s_bit = -1, s_starts = 0, s_stops = 0, s_txn = 0;
  bit s_on = 0, s_addrph = 0, s_sel = 0, s_rd = 0, s_send = 0, s_go = 0, s_mack = 0;
  logic [7:0] s_sh = 0, s_tx = 0, s_rx = 0, s_lastaddr = 0;

  always @(negedge sda_w) if (rst_n && scl_w === 1'b1) begin
    s_on = 1; s_bit = -1; s_addrph = 1; s_sel = 0; s_send = 0; s_go = 0; s_low = 0; s_starts++;
  end
  always @(posedge sda_w) if (rst_n && scl_w === 1'b1) begin
    s_on = 0; s_send = 0; s_go = 0; s_low = 0; s_stops++;
  end
  always @(posedge scl_w) if (rst_n && s_on) begin
    if (s_bit >= 0 && s_bit < 8) s_sh = {s_sh[6:0], sda_w};
    else if (s_bit == 8 && s_send) s_mack = !sda_w;
  end
  always @(negedge scl_w) if (rst_n && s_on) begin
    if (s_bit == -1 || s_bit == 8) begin
      if (s_bit == 8 && s_send && !s_mack) s_send = 0;
      if (s_go) begin s_send = 1; s_go = 0; end
      s_bit = 0;
      if (s_send) begin s_tx = rd_byte(s_txn); s_txn++; s_low = !s_tx[7]; end
      else s_low = 0;
    end else if (s_bit < 7) begin
      s_bit++;
      s_low = s_send ? !s_tx[7 - s_bit] : 1'b0;
    end else begin
      s_bit = 8;
      if (s_send) s_low = 0;
      else if (s_addrph) begin
        s_addrph = 0; s_lastaddr = s_sh; s_sel = (s_sh[7:1] == SLV); s_rd = s_sh[0];
        s_low = s_sel; s_go = s_sel && s_sh[0];
      end else begin
        s_rx = s_sh; s_low = s_sel && s_sh != 8'hFF;
      end
    end
  end

  // SDA edges while SCL stays high (R11 monitor)
  int hi_toggles = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (p_scl && scl_w && (p_sda != sda_w)) hi_toggles++;
      p_scl = scl_w; p_sda = sda_w;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic wait_flag(input string tag);
    int t = 0;
    while (!irq && t < 20000) begin @(negedge clk); t++; end
    chk({tag, " flag"}, int'(irq), 1);
  endtask

  task automatic wait_idle(input string tag);
    logic [7:0] v;
    int t = 0;
    rreg(A_STAT, v);
    while (v != 8'hF8 && t < 20000) begin rreg(A_STAT, v); t++; end
    chk({tag, " idle status"}, v, 8'hF8);
  endtask

  task automatic step_status(input string tag, input logic [7:0] ctl, input logic [7:0] exp);
    logic [7:0] v;
    wreg(A_CTRL, ctl);
    wait_flag(tag);
    rreg(A_STAT, v);
    chk({tag, " status"}, v, exp);
  endtask

  task automatic measure(output int per);
    int n = 0, t1 = -1;
    logic prev = scl_oe;
    per = -1;
    while (n < 100000 && per < 0) begin
      @(negedge clk); n++;
      if (prev && !scl_oe) begin
        if (t1 < 0) t1 = n; else per = n - t1;
      end
      prev = scl_oe;
    end
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int st0, sp0, per;
    logic [7:0] wpat [5] = '{8'h00, 8'h81, 8'h5A, 8'hFF, 8'h3C};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rreg(A_STAT, v); chk("R1 status", v, 8'hF8);
    rreg(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 flag", int'(irq), 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);

    // R2 no enable: start bit alone does nothing
    wreg(A_CTRL, 8'h20);
    repeat (60) @(negedge clk);
    rreg(A_STAT, v); chk("R2 status", v, 8'hF8);
    chk("R2 lines", {scl_oe, sda_oe, irq}, 0);
    chk("R2 no start", s_starts, 0);

    // R8 stop while idle
    wreg(A_CTRL, 8'h50);
    repeat (60) @(negedge clk);
    rreg(A_STAT, v); chk("R8 idle stop status", v, 8'hF8);
    chk("R8 idle stop lines", {scl_oe, sda_oe, irq}, 0);
    chk("R8 idle stop bus", s_starts + s_stops, 0);

    // R3 start from idle
    step_status("R3", 8'h60, 8'h08);
    chk("R3 start seen", s_starts, 1);
    chk("R3 lines held", {scl_oe, sda_oe}, 2'b11);
    rreg(A_CTRL, v); chk("R10 flag readback", v, 8'h48);

    // R5 write address acked
    wreg(A_DATA, {SLV, 1'b0});
    step_status("R5 wr addr", 8'h40, 8'h18);
    chk("R5 addr byte", s_lastaddr, {SLV, 1'b0});

    // R6 data bytes
    foreach (wpat[i]) begin
      wreg(A_DATA, wpat[i]);
      step_status("R6 data", 8'h40, (wpat[i] == 8'hFF) ? 8'h30 : 8'h28);
      chk("R6 byte on bus", s_rx, wpat[i]);
    end

    // R10 control write landing in the completion cycle
    wreg(A_DATA, 8'h33);
    wreg(A_CTRL, 8'h40);
    sp0 = s_stops;
    while (!irq) begin
      @(negedge clk);
      if (!irq) begin reg_we = 1'b1; reg_addr = A_CTRL; reg_wdata = 8'h50; end
      else reg_we = 1'b0;
    end
    reg_we = 1'b0;
    repeat (30) @(negedge clk);
    chk("R10 flag kept", int'(irq), 1);
    rreg(A_STAT, v); chk("R10 status", v, 8'h28);
    chk("R10 byte", s_rx, 8'h33);
    chk("R10 scl held", int'(scl_oe), 1);
    chk("R10 no stop", s_stops, sp0);

    // R4 repeated start, then R5/R7 read
    step_status("R4", 8'h60, 8'h10);
    wreg(A_DATA, {SLV, 1'b1});
    step_status("R5 rd addr", 8'h40, 8'h40);
    for (int k = 0; k < 3; k++) begin
      step_status("R7 read", (k < 2) ? 8'h44 : 8'h40, (k < 2) ? 8'h50 : 8'h58);
      rreg(A_DATA, v); chk("R7 data", v, rd_byte(k));
      chk("R7 master ack", int'(s_mack), (k < 2) ? 1 : 0);
    end

    // R8 stop
    sp0 = s_stops;
    wreg(A_CTRL, 8'h50);
    wait_idle("R8");
    chk("R8 stop seen", s_stops, sp0 + 1);
    chk("R8 lines released", {scl_oe, sda_oe, irq}, 0);

    // R12 start and stop together
    st0 = s_starts; sp0 = s_stops;
    step_status("R12", 8'h70, 8'h08);
    chk("R12 start only", s_starts - st0 + 10 * (s_stops - sp0), 1);
    wreg(A_DATA, 8'h22);
    step_status("R5 wr nack", 8'h40, 8'h20);
    step_status("R4 again", 8'h60, 8'h10);
    wreg(A_DATA, 8'h23);
    step_status("R5 rd nack", 8'h40, 8'h48);
    wreg(A_CTRL, 8'h50);
    wait_idle("R8 again");

    // R9 clock sweep
    for (int p = 0; p <= 2; p += 2)
      for (int m = 0; m <= 2; m++)
        for (int n = 0; n <= 2; n++) begin
          wreg(A_PER, 8'(p));
          wreg(A_DIV, 8'((m << 3) | n));
          step_status("R9 start", 8'h60, 8'h08);
          wreg(A_DATA, 8'h22);
          wreg(A_CTRL, 8'h40);
          measure(per);
          chk("R9 scl period", per, 20 * (p + 1) * (m + 1) * (1 << n));
          wait_flag("R9 byte");
          rreg(A_STAT, v); chk("R9 status", v, 8'h20);
          wreg(A_CTRL, 8'h50);
          wait_idle("R9");
        end

    // R11 SDA moved with SCL high only at start and stop
    chk("R11 sda edges with scl high", hi_toggles, s_starts + s_stops);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule